// File: doc/BRIEF.md
# Spare-Extensible SEC-DED Codec

This block encodes and decodes one memory word under a single-error-correcting, double-error-detecting code whose parity-check matrix has distinct odd-weight columns. On the write side it computes the base check bits and a set of extra check bits. The extra check bits are meant for spare memory columns that column repair left unused. On the read side it recomputes both sets from the read data, forms the syndrome and corrects a single flipped bit. It raises flags for a detected error, a corrected error and an uncorrectable error.

Each extra check bit has its own spare-used flag. While a spare is free, its syndrome bit takes part in detection and correction, which lowers the chance of miscorrecting multi-bit errors. Once repair has consumed that spare, its syndrome bit is masked out of both detection and correction. With every flag set, the codec acts exactly like the plain base code.

The code is set by parameters. These are the data width, the number of base and extra check bits, and the data columns of the base and extra rows. Check-bit columns are always identity columns. The whole block is combinational.

Top module: `spare_secded_codec`

## Requirements
- R1: `wr_chk_base` bit j is the XOR of the `wr_data` bits whose base column has a 1 in row j. With the default code the data columns (row 0 at bit 0) are 4'b1101, 4'b1011 and 4'b1110 for data bits 0, 1 and 2.
- R2: `wr_chk_extra` bit k is the XOR of the data bits whose extra column has a 1 in row k. With the default code the single extra row equals data bit 1.
- R3: When the read word matches its check bits, all three flags are low and `rd_data_fix` equals `rd_data`.
- R4: A single flipped bit anywhere among the data bits, the base check bits or the extra check bits with free spares is flagged. `err_seen` and `err_fixed` are high, `err_fatal` is low, and `rd_data_fix` returns the written data.
- R5: A single flipped check bit (base, or extra with a free spare) is reported as corrected and leaves `rd_data_fix` equal to `rd_data`.
- R6: Any two flipped bits that count (not in a used spare) give `err_seen` and `err_fatal` high and `err_fixed` low, and `rd_data_fix` equals `rd_data`.
- R7: When `spare_used[k]` is 1, extra check bit k has no effect. Flipping it alone raises no flag. Flipping it together with one other bit gives the single-error result for that other bit.
- R8: `err_fixed` is never high without `err_seen`, and `err_fatal` is high exactly when `err_seen` is high and `err_fixed` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data | input | DATA_W | Data word to encode |
| wr_chk_base | output | BASE_W | Base check bits for wr_data |
| wr_chk_extra | output | EXTRA_W | Extra check bits for wr_data, one per spare column |
| rd_data | input | DATA_W | Data word as read from memory |
| rd_chk_base | input | BASE_W | Base check bits as read |
| rd_chk_extra | input | EXTRA_W | Extra check bits as read from the spare columns |
| spare_used | input | EXTRA_W | Per-spare flag; 1 means that spare went to repair and its bit is ignored |
| rd_data_fix | output | DATA_W | Read data after correction |
| err_seen | output | 1 | Effective syndrome is non-zero |
| err_fixed | output | 1 | Effective syndrome matched one column and was corrected |
| err_fatal | output | 1 | Error seen but not correctable |

## Verification
Every output is a combinational function of the inputs present in the same cycle, so each result is due within the cycle in which its stimulus is applied. The bench changes the inputs just after a rising clock edge and reads all outputs at the following falling edge. By then the logic has settled and no new stimulus has arrived. Each error pattern is therefore checked against the one word that produced it.

// File: rtl/spare_secded_codec.sv
module spare_secded_codec #(
  parameter int DATA_W  = 3,
  parameter int BASE_W  = 4,
  parameter int EXTRA_W = 1,
  parameter logic [DATA_W*BASE_W-1:0]  H_BASE  = 12'hEBD,
  parameter logic [DATA_W*EXTRA_W-1:0] H_EXTRA = 3'b010
) (
  input  logic [DATA_W-1:0]  wr_data,
  output logic [BASE_W-1:0]  wr_chk_base,
  output logic [EXTRA_W-1:0] wr_chk_extra,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic [BASE_W-1:0]  rd_chk_base,
  input  logic [EXTRA_W-1:0] rd_chk_extra,
  input  logic [EXTRA_W-1:0] spare_used,
  output logic [DATA_W-1:0]  rd_data_fix,
  output logic               err_seen,
  output logic               err_fixed,
  output logic               err_fatal
);
  localparam logic [BASE_W-1:0]  ONE_B = BASE_W'(1);
  localparam logic [EXTRA_W-1:0] ONE_X = EXTRA_W'(1);

  logic [BASE_W-1:0]  calc_b, syn_b;
  logic [EXTRA_W-1:0] calc_x, syn_x, eff_x;
  logic [DATA_W-1:0]  hit_d;
  logic [BASE_W-1:0]  hit_cb;
  logic [EXTRA_W-1:0] hit_cx;

  always_comb begin
    wr_chk_base  = '0;
    wr_chk_extra = '0;
    calc_b = '0;
    calc_x = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (wr_data[i]) begin
        wr_chk_base  = wr_chk_base  ^ H_BASE[i*BASE_W +: BASE_W];
        wr_chk_extra = wr_chk_extra ^ H_EXTRA[i*EXTRA_W +: EXTRA_W];
      end
      if (rd_data[i]) begin
        calc_b = calc_b ^ H_BASE[i*BASE_W +: BASE_W];
        calc_x = calc_x ^ H_EXTRA[i*EXTRA_W +: EXTRA_W];
      end
    end
  end

  assign syn_b = calc_b ^ rd_chk_base;
  assign syn_x = calc_x ^ rd_chk_extra;
  assign eff_x = syn_x & ~spare_used;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      hit_d[i] = (syn_b == H_BASE[i*BASE_W +: BASE_W]) &&
                 (((syn_x ~^ H_EXTRA[i*EXTRA_W +: EXTRA_W]) | spare_used) == '1);
    for (int j = 0; j < BASE_W; j++)
      hit_cb[j] = (syn_b == (ONE_B << j)) && (eff_x == '0);
    for (int k = 0; k < EXTRA_W; k++)
      hit_cx[k] = (syn_b == '0) && (eff_x == (ONE_X << k));
  end

  assign err_seen    = (|syn_b) | (|eff_x);
  assign err_fixed   = (|hit_d) | (|hit_cb) | (|hit_cx);
  assign err_fatal   = err_seen & ~err_fixed;
  assign rd_data_fix = rd_data ^ hit_d;
endmodule

module spare_secded_codec_chk #(
  parameter int DATA_W = 3
) (
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] rd_data_fix,
  input logic              err_seen,
  input logic              err_fixed,
  input logic              err_fatal
);
  always_comb begin
    AST_FIX_NEEDS_SEEN: assert (!err_fixed || err_seen); // R8
    AST_FATAL_NOT_FIXED: assert (!(err_fatal && err_fixed)); // R6
    AST_QUIET_PASSES: assert (err_seen || rd_data_fix == rd_data); // R3
    AST_AT_MOST_ONE_FLIP: assert ($countones(rd_data_fix ^ rd_data) <= 1); // R4
    AST_FLIP_MEANS_FIXED: assert (rd_data_fix == rd_data || err_fixed); // R4
    AST_FATAL_NO_FLIP: assert (!err_fatal || rd_data_fix == rd_data); // R6
  end
endmodule

bind spare_secded_codec spare_secded_codec_chk #(.DATA_W(DATA_W)) u_chk (
  .rd_data(rd_data),
  .rd_data_fix(rd_data_fix),
  .err_seen(err_seen),
  .err_fixed(err_fixed),
  .err_fatal(err_fatal)
);

// File: tb/sim_spare_secded_codec.sv
module sim_spare_secded_codec;
  localparam int NW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] wr_data, rd_data, rd_data_fix;
  logic [3:0] wr_chk_base, rd_chk_base;
  logic [0:0] wr_chk_extra, rd_chk_extra, spare_used;
  logic err_seen, err_fixed, err_fatal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  spare_secded_codec u0 (
    .wr_data(wr_data), .wr_chk_base(wr_chk_base), .wr_chk_extra(wr_chk_extra),
    .rd_data(rd_data), .rd_chk_base(rd_chk_base), .rd_chk_extra(rd_chk_extra),
    .spare_used(spare_used), .rd_data_fix(rd_data_fix),
    .err_seen(err_seen), .err_fixed(err_fixed), .err_fatal(err_fatal)
  );

  function automatic logic [3:0] ref_base(input logic [2:0] d);
    ref_base = (d[0] ? 4'b1101 : 4'b0) ^ (d[1] ? 4'b1011 : 4'b0) ^ (d[2] ? 4'b1110 : 4'b0);
  endfunction

  function automatic logic ref_ext(input logic [2:0] d);
    ref_ext = d[1];
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic run_case(input logic [2:0] d, input logic [NW-1:0] mask, input logic used);
    logic [NW-1:0] word, eff;
    logic [2:0] exp_flags, got_flags, exp_data;
    string req;
    int n;
    @(posedge clk);
    word = {ref_ext(d), ref_base(d), d} ^ mask;
    wr_data = d;
    rd_data = word[2:0];
    rd_chk_base = word[6:3];
    rd_chk_extra = word[7];
    spare_used = used;
    @(negedge clk);
    check(wr_chk_base == ref_base(d), "R1", int'(wr_chk_base), int'(ref_base(d)));
    check(wr_chk_extra == ref_ext(d), "R2", int'(wr_chk_extra), int'(ref_ext(d)));
    eff = mask & ~{used, 7'b0};
    n = $countones(eff);
    if (n == 0) begin
      exp_flags = 3'b000; exp_data = d;
      req = (mask != 0) ? "R7" : "R3";
    end else if (n == 1) begin
      exp_flags = 3'b110; exp_data = d;
      req = (eff[2:0] == 0) ? "R5" : ((mask != eff) ? "R7" : "R4");
    end else begin
      exp_flags = 3'b101; exp_data = word[2:0];
      req = "R6";
    end
    got_flags = {err_seen, err_fixed, err_fatal};
    check(got_flags == exp_flags, {req, " flags"}, int'(got_flags), int'(exp_flags));
    check(rd_data_fix == exp_data, {req, " data"}, int'(rd_data_fix), int'(exp_data));
    check(err_fatal == (err_seen && !err_fixed), "R8", int'(err_fatal), int'(err_seen && !err_fixed));
  endtask

  initial begin
    wr_data = '0; rd_data = '0; rd_chk_base = '0; rd_chk_extra = '0; spare_used = '0;
    @(negedge clk);
    check({err_seen, err_fixed, err_fatal} == 3'b000, "R3 idle", int'({err_seen, err_fixed, err_fatal}), 0);
    for (int u = 0; u < 2; u++)
      for (int d = 0; d < 8; d++) begin
        run_case(3'(d), '0, u[0]);
        for (int a = 0; a < NW; a++) begin
          run_case(3'(d), NW'(1) << a, u[0]);
          for (int b = a + 1; b < NW; b++)
            run_case(3'(d), (NW'(1) << a) | (NW'(1) << b), u[0]);
        end
      end
    void'($urandom(32'd1234));
    for (int r = 0; r < 200; r++) begin
      logic [NW-1:0] m;
      m = NW'(1) << ($urandom % NW);
      if ($urandom % 2) m = m | (NW'(1) << ($urandom % NW));
      run_case(3'($urandom), m, 1'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule